// File: doc/BRIEF.md
# Privilege-Checked Peripheral Register Decoder

This block sits between a system bus and the register file of a serial peripheral module. It recognises accesses that fall in the module's 1 KB address window and splits that window into areas. A small global configuration area is always reserved for supervisor accesses. A larger assignable area holds the submodule control and status words and three queue RAM blocks. One bit in the configuration word decides at run time whether the assignable area is closed to user accesses or open to them. Accesses that are not allowed fail silently: reads return zero and writes change nothing. Every access in the window is still acknowledged.

The bus handshake is single-cycle and driven by a two-state machine. In `ST_IDLE`, a request that hits the window takes the `HIT` transition to `ST_ACK`. In `ST_ACK`, `ack` is high, and the machine either stays in `ST_ACK` on a back-to-back hit (`CHAIN`) or returns to `ST_IDLE` (`DONE`). A request that misses the window takes the `MISS` transition, which holds or returns the machine to `ST_IDLE`. The base of the window is chosen by a map-select input. The block also pulses a one-hot write strobe for each control word it updates, so that neighbouring logic can react to the update.

Top module: `prv_reg_decoder`

## Requirements
- R1: An access hits the window only when addr[23:20] equals {map_sel,3'b111} and addr[19:10] are all ones. addr[9:0] is the byte offset, and addr[0] is ignored. An access outside the window gets no acknowledge and has no effect.
- R2: Each request that hits the window is answered by `ack` high for exactly the next cycle. Back-to-back requests are each answered in turn.
- R3: Offsets 0x00–0x07 form the global area (configuration, test and interrupt words). The global area is reachable only with sup=1. With sup=0 a read returns 0 and a write changes nothing, including the protection bit.
- R4: The protection bit is bit 7 of the configuration word at offset 0x00. Offsets 0x08–0x1F and the queue RAM form the assignable area. When the protection bit is 1, the assignable area behaves like the global area for user accesses. When it is 0, user accesses read and write the assignable area normally.
- R5: Reset sets the configuration word to 0x0080, so the protection bit is 1. All other words reset to 0, and `ack`, `rdata` and `reg_wstb` reset low.
- R6: The reserved offsets read 0 and ignore writes at any privilege level. They are 0x06, 0x10, 0x12, 0x20–0xFF and 0x150–0x3FF.
- R7: The queue RAM has three blocks. The receive block is at offsets 0x100–0x11F (16 words), the transmit block at 0x120–0x13F (16 words) and the command block at 0x140–0x14F (8 words). Every word in these blocks is separately stored.
- R8: be[1] enables the write of wdata[15:8] and be[0] enables the write of wdata[7:0]. A byte whose enable is low keeps its value.
- R9: reg_wstb[k] is high in the acknowledge cycle of an allowed write to control word k (offset 2k). No strobe is raised for a blocked write, a reserved offset or a queue RAM write.
- R10: A write access returns rdata 0. A read returns the word's contents as they stood in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access request, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| sup | input | 1 | 1 = supervisor access, 0 = user access |
| map_sel | input | 1 | Selects the window base (top address nibble {map_sel,111}) |
| addr | input | 24 | Byte address |
| wdata | input | 16 | Write data |
| be | input | 2 | Byte enables (bit 1 = upper byte) |
| ack | output | 1 | Acknowledge, high the cycle after a hit |
| rdata | output | 16 | Read data, valid with ack |
| reg_wstb | output | 16 | One-hot write strobe per control word |

## Verification
Directed cases try each pairing of privilege level and protection bit against the global area, the assignable control words and the queue RAM. Among them is a user write that tries to clear the protection bit. This separates a gate that checks only the region from one that also tracks the run-time bit.

A random stream of several hundred accesses then mixes the following at random:
- offsets in the control words, the RAM blocks, the reserved gaps and outside the window;
- odd byte addresses;
- both map selections;
- byte-enable patterns.

Supervisor writes to the configuration word toggle the protection bit along the way. Read-back after each write shows that blocked writes and writes to reserved offsets leave no trace. Chained requests show that the acknowledge pipeline does not drop or merge accesses.

// File: rtl/prv_pkg.sv
package prv_pkg;
    localparam int ADDR_W      = 24;
    localparam int DATA_W      = 16;
    localparam int BE_W        = DATA_W / 8;
    localparam int OFF_W       = 10;
    localparam int NREG        = 16;
    localparam int REG_IW      = $clog2(NREG);
    localparam int GLOBAL_WORDS = 4;
    localparam int RX_WORDS    = 16;
    localparam int TX_WORDS    = 16;
    localparam int CMD_WORDS   = 8;
    localparam int RAM_WORDS   = RX_WORDS + TX_WORDS + CMD_WORDS;
    localparam int RAM_IW      = $clog2(RAM_WORDS);
    localparam int RAM_BASE    = 'h100;
    localparam int PROT_BIT    = 7;
    localparam logic [DATA_W-1:0] CFG_RESET = DATA_W'(1) << PROT_BIT;
    localparam logic [NREG-1:0]   RSVD_MASK = 16'h0308;

    typedef enum logic [2:0] {
        RG_MISS,
        RG_GLOBAL,
        RG_ASSIGN,
        RG_QRAM,
        RG_RSVD
    } region_t;

    typedef enum logic {
        ST_IDLE,
        ST_ACK
    } bus_st_t;
endpackage

// File: rtl/prv_addr_decode.sv
module prv_addr_decode
    import prv_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              map_sel,
    output region_t           region,
    output logic [REG_IW-1:0] reg_idx,
    output logic [RAM_IW-1:0] ram_idx
);
    localparam int REG_SPAN = 2 * NREG;
    localparam int RAM_END  = RAM_BASE + 2 * RAM_WORDS;

    logic [OFF_W-1:0] off;
    logic [OFF_W-1:0] ram_rel;
    logic             hit;

    assign off     = addr[OFF_W-1:0];
    assign ram_rel = off - OFF_W'(RAM_BASE);
    assign hit     = (addr[ADDR_W-1 -: 4] == {map_sel, 3'b111}) &&
                     (&addr[ADDR_W-5:OFF_W]);

    always_comb begin
        region  = RG_MISS;
        reg_idx = off[REG_IW:1];
        ram_idx = ram_rel[RAM_IW:1];
        if (hit) begin
            if (int'(off) < REG_SPAN) begin
                if (RSVD_MASK[reg_idx])
                    region = RG_RSVD;
                else if (int'(reg_idx) < GLOBAL_WORDS)
                    region = RG_GLOBAL;
                else
                    region = RG_ASSIGN;
            end else if (int'(off) >= RAM_BASE && int'(off) < RAM_END) begin
                region = RG_QRAM;
            end else begin
                region = RG_RSVD;
            end
        end
    end
endmodule

// File: rtl/prv_priv_gate.sv
module prv_priv_gate
    import prv_pkg::*;
(
    input  region_t region,
    input  logic    sup,
    input  logic    prot,
    output logic    allow
);
    always_comb begin
        unique case (region)
            RG_GLOBAL:          allow = sup;
            RG_ASSIGN, RG_QRAM: allow = sup || !prot;
            default:            allow = 1'b0;
        endcase
    end

    always_comb begin
        if (region == RG_GLOBAL && !sup)
            a_global_user_blocked_r3: assert (!allow);
        if (region == RG_RSVD || region == RG_MISS)
            a_rsvd_blocked_r6: assert (!allow);
    end
endmodule

// File: rtl/prv_store.sv
module prv_store
    import prv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  region_t           region,
    input  logic [REG_IW-1:0] reg_idx,
    input  logic [RAM_IW-1:0] ram_idx,
    input  logic [BE_W-1:0]   be,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_word,
    output logic              prot
);
    logic [DATA_W-1:0] regs [NREG];
    logic [DATA_W-1:0] ram  [RAM_WORDS];

    function automatic logic [DATA_W-1:0] merge(
        input logic [DATA_W-1:0] old_v,
        input logic [DATA_W-1:0] new_v,
        input logic [BE_W-1:0]   en
    );
        logic [DATA_W-1:0] r;
        r = old_v;
        for (int b = 0; b < BE_W; b++)
            if (en[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
        return r;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++)
                regs[i] <= (i == 0) ? CFG_RESET : '0;
        end else if (wr_en && (region == RG_GLOBAL || region == RG_ASSIGN)) begin
            regs[reg_idx] <= merge(regs[reg_idx], wdata, be);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < RAM_WORDS; i++)
                ram[i] <= '0;
        end else if (wr_en && region == RG_QRAM) begin
            ram[ram_idx] <= merge(ram[ram_idx], wdata, be);
        end
    end

    always_comb begin
        unique case (region)
            RG_GLOBAL, RG_ASSIGN: rd_word = regs[reg_idx];
            RG_QRAM:              rd_word = ram[ram_idx];
            default:              rd_word = '0;
        endcase
    end

    assign prot = regs[0][PROT_BIT];

    p_rsvd_words_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (regs[3] == '0) && (regs[8] == '0) && (regs[9] == '0));
endmodule

// File: rtl/prv_reg_decoder.sv
module prv_reg_decoder
    import prv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic              sup,
    input  logic              map_sel,
    input  logic [23:0]       addr,
    input  logic [15:0]       wdata,
    input  logic [1:0]        be,
    output logic              ack,
    output logic [15:0]       rdata,
    output logic [15:0]       reg_wstb
);
    bus_st_t           state_q, state_d;
    region_t           region;
    logic [REG_IW-1:0] reg_idx;
    logic [RAM_IW-1:0] ram_idx;
    logic              allow;
    logic              prot;
    logic              hit_req;
    logic              wr_ok;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] rdata_q;
    logic [NREG-1:0]   wstb_q;

    prv_addr_decode u_dec (
        .addr    (addr),
        .map_sel (map_sel),
        .region  (region),
        .reg_idx (reg_idx),
        .ram_idx (ram_idx)
    );

    prv_priv_gate u_gate (
        .region (region),
        .sup    (sup),
        .prot   (prot),
        .allow  (allow)
    );

    prv_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_ok),
        .region  (region),
        .reg_idx (reg_idx),
        .ram_idx (ram_idx),
        .be      (be),
        .wdata   (wdata),
        .rd_word (rd_word),
        .prot    (prot)
    );

    assign hit_req = req && (region != RG_MISS);
    assign wr_ok   = hit_req && we && allow;

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = hit_req ? ST_ACK : ST_IDLE;
            ST_ACK:  state_d = hit_req ? ST_ACK : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            wstb_q  <= '0;
        end else begin
            rdata_q <= (hit_req && !we && allow) ? rd_word : '0;
            wstb_q  <= '0;
            if (wr_ok && region != RG_QRAM)
                wstb_q[reg_idx] <= 1'b1;
        end
    end

    assign ack      = (state_q == ST_ACK);
    assign rdata    = rdata_q;
    assign reg_wstb = wstb_q;

    p_ack_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_req |=> ack);
    p_no_stray_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_req |=> !ack);
    p_blocked_read_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_req && !we && !allow) |=> (rdata == '0));
    p_user_keeps_prot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !sup) |=> $stable(prot));
    p_wstb_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reg_wstb));
    p_wstb_with_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wstb != '0) |-> ack);
    p_write_rdata_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we) |=> (rdata == '0));
endmodule

// File: tb/tb_prv_reg_decoder.sv
`timescale 1ns/1ps
module tb_prv_reg_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0, sup = 1'b0, map_sel = 1'b0;
    logic [23:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [1:0]  be = '0;
    logic        ack;
    logic [15:0] rdata;
    logic [15:0] reg_wstb;

    int n_chk = 0;
    int n_fail = 0;

    logic [15:0] mreg [16];
    logic [15:0] mram [40];
    logic        mprot;

    always #10 clk = ~clk;

    prv_reg_decoder dut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .sup(sup),
        .map_sel(map_sel), .addr(addr), .wdata(wdata), .be(be),
        .ack(ack), .rdata(rdata), .reg_wstb(reg_wstb)
    );

    // kinds: 0 outside window, 1 global, 2 assignable word, 3 queue RAM, 4 reserved
    function automatic int kind_of(input logic [23:0] a, input logic m);
        int off;
        int w;
        if (a[23:20] != {m, 3'b111} || a[19:10] != 10'h3FF) return 0;
        off = int'(a[9:0]) & 'h3FE;
        if (off < 'h20) begin
            w = off / 2;
            if (w == 3 || w == 8 || w == 9) return 4;
            return (w < 4) ? 1 : 2;
        end
        if (off >= 'h100 && off < 'h150) return 3;
        return 4;
    endfunction

    function automatic int idx_of(input logic [23:0] a, input int k);
        int off;
        off = int'(a[9:0]) & 'h3FE;
        return (k == 3) ? (off - 'h100) / 2 : off / 2;
    endfunction

    function automatic bit allowed(input int k, input logic s, input logic p);
        if (k == 1) return s;
        if (k == 2 || k == 3) return s || !p;
        return 0;
    endfunction

    function automatic string tag_of(input int k);
        case (k)
            0: return "R1";
            1: return "R3";
            2: return "R4";
            3: return "R7";
            default: return "R6";
        endcase
    endfunction

    function automatic logic [15:0] mrg(input logic [15:0] o, input logic [15:0] n,
                                        input logic [1:0] b);
        return {b[1] ? n[15:8] : o[15:8], b[0] ? n[7:0] : o[7:0]};
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic s, input logic m,
                          input logic [23:0] a, input logic [15:0] d,
                          input logic [1:0] b, output logic [15:0] got);
        int k;
        int ix;
        bit ok;
        logic [15:0] exp_rd;
        logic [15:0] exp_stb;
        k  = kind_of(a, m);
        ix = idx_of(a, k);
        ok = allowed(k, s, mprot);
        exp_rd = '0;
        if (!w && ok) exp_rd = (k == 3) ? mram[ix] : mreg[ix];
        exp_stb = '0;
        if (w && ok && k != 3) exp_stb[ix] = 1'b1;
        @(negedge clk);
        req = 1'b1; we = w; sup = s; map_sel = m; addr = a; wdata = d; be = b;
        @(negedge clk);
        req = 1'b0;
        chk((k == 0) ? "R1" : "R2", {15'd0, ack}, {15'd0, k != 0});
        chk(w ? "R10" : tag_of(k), rdata, exp_rd);
        chk("R9", reg_wstb, exp_stb);
        got = rdata;
        if (w && ok) begin
            if (k == 3) mram[ix] = mrg(mram[ix], d, b);
            else        mreg[ix] = mrg(mreg[ix], d, b);
        end
        mprot = mreg[0][7];
    endtask

    function automatic logic [23:0] mk(input logic m, input int off);
        return {m, 3'b111, 10'h3FF, 10'(off)};
    endfunction

    initial begin
        #(200000 * 20);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] g;
        logic [23:0] a;
        int off;
        void'($urandom(1234));
        for (int i = 0; i < 16; i++) mreg[i] = '0;
        for (int i = 0; i < 40; i++) mram[i] = '0;
        mreg[0] = 16'h0080;
        mprot = 1'b1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R5", {15'd0, ack}, 16'd0);
        chk("R5", rdata, 16'd0);
        chk("R5", reg_wstb, 16'd0);

        // R5: configuration word reset value
        access(0, 1, 0, mk(0, 'h00), 0, 2'b11, g);
        chk("R5", g, 16'h0080);
        // R3: user read of global area and user attempt to clear protection
        access(0, 0, 0, mk(0, 'h04), 0, 2'b11, g);
        access(1, 0, 0, mk(0, 'h00), 16'h0000, 2'b11, g);
        access(0, 1, 0, mk(0, 'h00), 0, 2'b11, g);
        chk("R3", g, 16'h0080);
        // R4: protected assignable word rejects user write
        access(1, 0, 0, mk(0, 'h18), 16'h1357, 2'b11, g);
        access(0, 1, 0, mk(0, 'h18), 0, 2'b11, g);
        chk("R4", g, 16'h0000);
        access(1, 0, 0, mk(0, 'h100), 16'h2468, 2'b11, g);
        // R4: open the assignable area, user accesses go through
        access(1, 1, 0, mk(0, 'h00), 16'h0000, 2'b11, g);
        access(1, 0, 0, mk(0, 'h18), 16'hBEEF, 2'b11, g);
        access(0, 0, 0, mk(0, 'h18), 0, 2'b11, g);
        chk("R4", g, 16'hBEEF);
        access(1, 0, 0, mk(0, 'h00), 16'h0080, 2'b11, g);
        access(0, 0, 0, mk(0, 'h00), 0, 2'b11, g);
        chk("R3", g, 16'h0000);
        // R8: byte enables on queue RAM
        access(1, 1, 1, mk(1, 'h100), 16'h1234, 2'b11, g);
        access(1, 1, 1, mk(1, 'h101), 16'hAB00, 2'b10, g);
        access(0, 1, 1, mk(1, 'h100), 0, 2'b11, g);
        chk("R8", g, 16'hAB34);
        // R7: last command word is distinct from first receive word
        access(1, 1, 0, mk(0, 'h14E), 16'h5A5A, 2'b11, g);
        access(0, 0, 0, mk(0, 'h14E), 0, 2'b11, g);
        chk("R7", g, 16'h5A5A);
        // R6: reserved offsets ignore supervisor writes
        access(1, 1, 0, mk(0, 'h10), 16'hFFFF, 2'b11, g);
        access(0, 1, 0, mk(0, 'h10), 0, 2'b11, g);
        chk("R6", g, 16'h0000);
        access(1, 1, 0, mk(0, 'h150), 16'hFFFF, 2'b11, g);
        // R1: wrong map selection is not answered
        access(0, 1, 1, mk(0, 'h18), 0, 2'b11, g);

        // R2: back-to-back requests
        @(negedge clk);
        req = 1'b1; we = 1'b0; sup = 1'b1; map_sel = 1'b0;
        addr = mk(0, 'h18); be = 2'b11;
        @(negedge clk);
        addr = mk(0, 'h14E);
        chk("R2", {15'd0, ack}, 16'd1);
        chk("R2", rdata, mreg[12]);
        @(negedge clk);
        req = 1'b0;
        chk("R2", {15'd0, ack}, 16'd1);
        chk("R2", rdata, mram[39]);
        @(negedge clk);
        chk("R2", {15'd0, ack}, 16'd0);

        // random mix
        for (int i = 0; i < 800; i++) begin
            logic m;
            int sel;
            m = 1'($urandom);
            sel = int'($urandom % 10);
            case (sel)
                0, 1, 2: off = int'($urandom % 32);
                3, 4, 5: off = 'h100 + int'($urandom % 80);
                6:       off = 'h20 + int'($urandom % 224);
                7:       off = 'h150 + int'($urandom % 688);
                8:       off = int'($urandom % 8);
                default: off = int'($urandom % 1024);
            endcase
            a = mk(m, off);
            if (sel == 9 && $urandom % 2 == 0) a[19:10] = 10'($urandom);
            if (sel == 9 && $urandom % 2 == 0) m = ~m;
            access(1'($urandom), 1'($urandom), m, a, 16'($urandom),
                   2'($urandom), g);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule